// File: doc/BRIEF.md
# Illegal Opcode Exception Trap Unit

This unit monitors every instruction word presented with its valid strobe and flags the reserved encoding that the processor must not execute. When such a word appears, the unit performs the whole exception entry in a single clock edge. It copies the restored PC into the exception-return PC register and the pre-trap status word into the exception-return status register. It writes a fixed cause code into the low half of the exception cause register, sets the trap-in-progress and interrupt-disable flags in the status word, and points the PC at a fixed handler address.

The unit owns the five architectural registers involved and exposes them as outputs. A combinational trap-taken pulse marks the cycle whose closing edge performs the entry. The exception cannot be masked: it is taken regardless of the current flag state, so two illegal words in a row trap twice.

Top module: `ilgop_trap_unit`

## Requirements
- R1: A word is illegal only when the strobe is high, instruction bits 10..5 are all ones and the 4-bit field at bits 26..23 holds a value from 3 to 15; every other bit is ignored.
- R2: On a trap, the exception-return PC register receives `restore_pc_i`.
- R3: On a trap, the exception-return status register receives the status word as it was before that edge.
- R4: On a trap, the cause register bits 15..0 become 0x0060 and bits 31..16 keep their value.
- R5: On a trap, status bit 6 (trap in progress) and bit 5 (interrupt disable) become 1, and bits 4..0 (Z=0, S=1, OV=2, CY=3, SAT=4) and bit 7 (NP) keep their value.
- R6: On a trap, the PC becomes 0x00000060.
- R7: After reset, the status word is 0x00000020 and the PC, return PC, return status and cause registers are zero.
- R8: `trap_o` is high exactly in the cycle whose rising edge performs the entry, and a trap is taken even when bits 6 and 5 are already set.
- R9: When the strobe is low or the word is legal, `trap_o` is low and no register changes.
- R10: Status bits 31..8 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 32 | Instruction word being issued |
| restore_pc_i | input | 32 | PC to resume at after the handler |
| psw_o | output | 32 | Status word |
| eipc_o | output | 32 | Exception-return PC |
| eipsw_o | output | 32 | Exception-return status word |
| ecr_o | output | 32 | Exception cause register |
| pc_o | output | 32 | Program counter |
| trap_o | output | 1 | Trap entry performed at this cycle's rising edge |

## Verification
The bench probes the field boundaries: a format value of 2 against 3, the maximum of 15, and a subop with a single zero bit. A decoder with an off-by-one compare or a wrong bit slice would trap on a legal word or miss an illegal one. An illegal word with the strobe low must leave all registers alone, which catches a decoder that ignores the strobe. Back-to-back illegal words check that the second save captures the already-flagged status word 0x60, which exposes a design that masks on the trap-in-progress flag or saves the post-trap value. Randomized words with other bits set confirm that don't-care bits are ignored and that the cause register's upper half stays unchanged.

// File: rtl/ilgop_pkg.sv
package ilgop_pkg;
  parameter int unsigned XLEN = 32;

  // status word bit positions
  localparam int unsigned PSW_Z   = 0;
  localparam int unsigned PSW_S   = 1;
  localparam int unsigned PSW_OV  = 2;
  localparam int unsigned PSW_CY  = 3;
  localparam int unsigned PSW_SAT = 4;
  localparam int unsigned PSW_ID  = 5;
  localparam int unsigned PSW_EP  = 6;
  localparam int unsigned PSW_NP  = 7;
  localparam int unsigned PSW_W   = 8;

  // illegal encoding fields
  localparam int unsigned SUB_LO  = 5;
  localparam int unsigned SUB_HI  = 10;
  localparam int unsigned FMT_LO  = 23;
  localparam int unsigned FMT_HI  = 26;
  localparam int unsigned FMT_MIN = 3;

  localparam int unsigned CAUSE_W = 16;
  localparam logic [CAUSE_W-1:0] CAUSE_ILGOP = 16'h0060;
  localparam logic [XLEN-1:0]    HANDLER_VEC = 32'h0000_0060;
  localparam logic [PSW_W-1:0]   PSW_RESET   = 8'h20;

  typedef struct packed {
    logic np;
    logic ep;
    logic id;
    logic sat;
    logic cy;
    logic ov;
    logic s;
    logic z;
  } psw_flags_t;
endpackage

// File: rtl/ilgop_decode.sv
module ilgop_decode
  import ilgop_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         valid_i,
  input  logic [W-1:0] instr_i,
  output logic         illegal_o
);
  localparam int unsigned SUB_W = SUB_HI - SUB_LO + 1;
  localparam int unsigned FMT_W = FMT_HI - FMT_LO + 1;
  localparam logic [FMT_W-1:0] FMT_MIN_V = FMT_W'(FMT_MIN);

  logic [SUB_W-1:0] subop;
  logic [FMT_W-1:0] fmt;

  assign subop = instr_i[SUB_HI:SUB_LO];
  assign fmt   = instr_i[FMT_HI:FMT_LO];

  assign illegal_o = valid_i && (&subop) && (fmt >= FMT_MIN_V);
endmodule

// File: rtl/ilgop_trap_state.sv
module ilgop_trap_state
  import ilgop_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter logic [W-1:0] PC_RESET = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trap_i,
  input  logic [W-1:0] restore_pc_i,
  output logic [W-1:0] psw_o,
  output logic [W-1:0] eipc_o,
  output logic [W-1:0] eipsw_o,
  output logic [W-1:0] ecr_o,
  output logic [W-1:0] pc_o
);
  localparam int unsigned ECR_HI_W = W - CAUSE_W;

  psw_flags_t            psw_q;
  logic [PSW_W-1:0]      eipsw_q;
  logic [W-1:0]          eipc_q, pc_q;
  logic [CAUSE_W-1:0]    cause_q;
  logic [ECR_HI_W-1:0]   ecr_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q    <= psw_flags_t'(PSW_RESET);
      eipsw_q  <= '0;
      eipc_q   <= '0;
      pc_q     <= PC_RESET;
      cause_q  <= '0;
      ecr_hi_q <= '0;
    end else if (trap_i) begin
      eipc_q   <= restore_pc_i;
      eipsw_q  <= psw_q;
      cause_q  <= CAUSE_ILGOP;
      psw_q.ep <= 1'b1;
      psw_q.id <= 1'b1;
      pc_q     <= HANDLER_VEC[W-1:0];
      ecr_hi_q <= ecr_hi_q;
    end
  end

  assign psw_o   = W'(psw_q);
  assign eipsw_o = W'(eipsw_q);
  assign eipc_o  = eipc_q;
  assign ecr_o   = {ecr_hi_q, cause_q};
  assign pc_o    = pc_q;
endmodule

// File: rtl/ilgop_trap_unit.sv
module ilgop_trap_unit
  import ilgop_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter logic [W-1:0] PC_RESET = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         instr_valid_i,
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] restore_pc_i,
  output logic [W-1:0] psw_o,
  output logic [W-1:0] eipc_o,
  output logic [W-1:0] eipsw_o,
  output logic [W-1:0] ecr_o,
  output logic [W-1:0] pc_o,
  output logic         trap_o
);
  logic illegal;

  ilgop_decode #(.W(W)) i_decode (
    .valid_i   (instr_valid_i),
    .instr_i   (instr_i),
    .illegal_o (illegal)
  );

  ilgop_trap_state #(.W(W), .PC_RESET(PC_RESET)) i_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_i       (illegal),
    .restore_pc_i (restore_pc_i),
    .psw_o        (psw_o),
    .eipc_o       (eipc_o),
    .eipsw_o      (eipsw_o),
    .ecr_o        (ecr_o),
    .pc_o         (pc_o)
  );

  assign trap_o = illegal;
endmodule

// File: rtl/ilgop_trap_unit_chk.sv
module ilgop_trap_unit_chk
  import ilgop_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         instr_valid_i,
  input logic [W-1:0] instr_i,
  input logic [W-1:0] restore_pc_i,
  input logic [W-1:0] psw_o,
  input logic [W-1:0] eipc_o,
  input logic [W-1:0] eipsw_o,
  input logic [W-1:0] ecr_o,
  input logic [W-1:0] pc_o,
  input logic         trap_o
);
  AST_TRAP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (instr_valid_i && (&instr_i[SUB_HI:SUB_LO]))); // R1
  AST_EIPC_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> eipc_o == $past(restore_pc_i)); // R2
  AST_EIPSW_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> eipsw_o == $past(psw_o)); // R3
  AST_CAUSE_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (ecr_o[CAUSE_W-1:0] == CAUSE_ILGOP) &&
               (ecr_o[W-1:CAUSE_W] == $past(ecr_o[W-1:CAUSE_W]))); // R4
  AST_FLAGS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> psw_o[PSW_EP] && psw_o[PSW_ID] && psw_o[PSW_NP] == $past(psw_o[PSW_NP]) &&
               psw_o[PSW_SAT:PSW_Z] == $past(psw_o[PSW_SAT:PSW_Z])); // R5
  AST_VECTOR_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> pc_o == HANDLER_VEC[W-1:0]); // R6
  AST_HOLD_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |=> $stable(psw_o) && $stable(eipc_o) && $stable(eipsw_o) &&
                $stable(ecr_o) && $stable(pc_o)); // R9
  AST_PSW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_o[W-1:PSW_W] == '0); // R10
endmodule

bind ilgop_trap_unit ilgop_trap_unit_chk #(.W(W)) i_chk (.*);

// File: tb/test_ilgop_trap_unit.sv
module test_ilgop_trap_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] restore_pc_i = '0;
  logic [31:0] psw_o, eipc_o, eipsw_o, ecr_o, pc_o;
  logic        trap_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_psw, m_eipc, m_eipsw, m_ecr, m_pc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ilgop_trap_unit i_ilgop_trap_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " R5 R10 psw"}, psw_o, m_psw);
    chk({tag, " R2 eipc"}, eipc_o, m_eipc);
    chk({tag, " R3 eipsw"}, eipsw_o, m_eipsw);
    chk({tag, " R4 ecr"}, ecr_o, m_ecr);
    chk({tag, " R6 pc"}, pc_o, m_pc);
  endtask

  function automatic bit is_illegal(input bit v, input logic [31:0] w);
    int sub = int'((w >> 5) & 32'h3f);
    int fmt = int'((w >> 23) & 32'hf);
    return v && (sub == 63) && (fmt >= 3) && (fmt <= 15);
  endfunction

  task automatic step(input string tag, input bit v, input logic [31:0] w, input logic [31:0] rpc);
    bit exp_trap;
    @(negedge clk_i);
    instr_valid_i = v;
    instr_i = w;
    restore_pc_i = rpc;
    exp_trap = is_illegal(v, w);
    #1;
    chk({tag, " R1 R8 R9 trap_o"}, {31'b0, trap_o}, {31'b0, exp_trap});
    @(posedge clk_i);
    if (exp_trap) begin
      m_eipc = rpc;
      m_eipsw = m_psw;
      m_ecr = {m_ecr[31:16], 16'h0060};
      m_psw = m_psw | 32'h60;
      m_pc = 32'h60;
    end
    #1;
    chk_regs(tag);
  endtask

  initial begin
    m_psw = 32'h20; m_eipc = '0; m_eipsw = '0; m_ecr = '0; m_pc = '0;
    repeat (3) @(negedge clk_i);
    chk_regs("reset R7");
    rst_ni = 1'b1;
    // strobe low with illegal word: ignored
    step("R9 no-valid", 1'b0, 32'h0180_07e0, 32'h1111_0000);
    // format 2 is legal
    step("R1 fmt2", 1'b1, 32'h0100_07e0, 32'h2222_0000);
    // one subop bit clear is legal
    step("R1 subop-gap", 1'b1, 32'h0180_07c0, 32'h3333_0000);
    step("R1 fmt0", 1'b1, 32'h0000_07e0, 32'h4444_0000);
    // lowest illegal format
    step("R1 fmt3 trap", 1'b1, 32'h0180_07e0, 32'h0000_1234);
    // back-to-back with flags already set, don't-care bits set
    step("R8 fmt15 trap", 1'b1, 32'hffff_ffff, 32'h0000_5678);
    step("R9 legal-after", 1'b1, 32'h0000_0000, 32'hdead_beef);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] w = $urandom;
      if (i % 2 == 0) w = w | 32'h0000_07e0;
      step("R1 random", ($urandom % 4) != 0, w, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule